// File: doc/BRIEF.md
# Zero-Turnaround Burst Synchronous SRAM

A single-port synchronous SRAM whose command interface never needs a dead cycle between a read and a write. On each enabled rising edge the block takes one command: load a read, load a write, continue the current burst, or deselect. Write data follows its command by one enabled edge. A read can therefore be issued on the edge that collects the previous write's data, and it sees that data.

Three chip-select pins must all be in their active state for a load to count. A clock-enable pin turns an edge into a stall that freezes every piece of state. A mode pin picks a linear or an interleaved order for the 4-word burst. Two active-low byte enables gate the two lanes of a write. A sleep pin freezes the block and floats the data outputs. The bidirectional data bus is split into an input word, an output word and a drive-enable.

The command controller is a three-state machine with the states ST_IDLE, ST_RD and ST_WR. Its transitions are:
- T_LOAD_RD: the load strobe is low, the block is selected and the write pin is high. The next state is ST_RD.
- T_LOAD_WR: the load strobe is low, the block is selected and the write pin is low. The next state is ST_WR.
- T_DESEL: the load strobe is low and the block is not selected. The next state is ST_IDLE.
- T_CONT: the load strobe is high and the state is ST_RD or ST_WR. The state is kept and the burst step advances.
- T_NOP: the load strobe is high and the state is ST_IDLE. The state stays ST_IDLE.
- T_STALL: clock enable is inactive. Nothing moves.
- T_SLEEP: sleep is high. The state is forced to ST_IDLE.

Top module: `zbt_sram`

## Requirements
- R1: A load counts only when sel1_n=0, sel2=1 and sel3_n=0. A load with any other combination deselects, and dq_oe is low for the whole next cycle.
- R2: For a write loaded or continued on an enabled edge, the write uses the dq_in value sampled on the next enabled edge.
- R3: byte_en_n is active low. Bit 0 gates data bits [7:0] and bit 1 gates bits [15:8]. A lane whose bit was high when the write command was sampled keeps its old contents.
- R4: A read's data is on dq_out during the cycle after its command edge, with dq_oe high, provided oe_n is low in that cycle. While oe_n is high, dq_oe=0 and dq_out=0.
- R5: An edge with clk_en_n=1 is a stall. No write is done, the burst state holds, and dq_oe and dq_out keep their values.
- R6: A write whose data edge is stalled completes on the next enabled edge, using dq_in from that edge.
- R7: With burst_ilv=0, the k-th continue step accesses low address bits (start+k) mod 4. The upper address bits stay unchanged.
- R8: With burst_ilv=1, the k-th continue step accesses low address bits start XOR k. The upper address bits stay unchanged.
- R9: A continue (adv_ld=1) while no access is active is a no-op. It leaves dq_oe low in the next cycle.
- R10: A read on the edge that completes a write to the same address returns the new data in the enabled lanes.
- R11: While sleep=1, edges change neither the storage nor any pending access, and dq_oe is low from the following cycle. After sleep, dq_oe stays low until a new read is done.
- R12: After reset, dq_oe=0 and dq_out=0, and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, sampled on a load |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | 0 = write, 1 = read, sampled on a load |
| clk_en_n | input | 1 | Clock enable, active low; 1 stalls the edge |
| adv_ld | input | 1 | 0 = load a new command, 1 = continue the burst |
| byte_en_n | input | DATA_W/8 | Byte-lane write enables, active low |
| burst_ilv | input | 1 | Burst order: 0 = linear, 1 = interleaved |
| sleep | input | 1 | Sleep request, legal only while deselected |
| oe_n | input | 1 | Output enable, active low |
| dq_in | input | DATA_W | Write data, one enabled edge after the command |
| dq_out | output | DATA_W | Read data, zero when not driven |
| dq_oe | output | 1 | High while dq_out drives the bus |

## Verification
Read data and the high-Z state after a deselect, no-op or sleep are due in the cycle after their command edge. Write data is consumed one enabled edge after its command, so a write only shows up through a later read. Each command the driver issues pushes one expected item, tagged with the edge count at which it falls due. A stall pushes a copy of the previous item, because the outputs must hold. The monitor compares items at the falling edge, after the edge has settled and while oe_n holds its value for that cycle.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } acc_st_e;

    // Low two address bits for burst step k from the start word.
    function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                            input logic [1:0] k,
                                            input logic       ilv);
        return ilv ? (start ^ k) : (start + k);
    endfunction

endpackage

// File: rtl/zbt_ctrl.sv
`timescale 1ns/1ps
module zbt_ctrl
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sleep,
    input  logic              selected,
    input  logic              wr_n,
    input  logic              adv_ld,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] addr,
    output logic              acc_valid,
    output logic              acc_wr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              busy
);

    acc_st_e           state_q, state_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [1:0]        cnt_q, cnt_d;

    // State register: T_SLEEP forces idle, T_STALL holds everything.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            cnt_q   <= '0;
        end else if (sleep) begin
            state_q <= ST_IDLE;
        end else if (en) begin
            state_q <= state_d;
            base_q  <= base_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and access outputs.
    always_comb begin
        state_d  = state_q;
        base_d   = base_q;
        cnt_d    = cnt_q;
        acc_addr = base_q;
        if (!adv_ld) begin
            base_d   = addr;
            cnt_d    = 2'd0;
            acc_addr = addr;
            if (selected)
                state_d = wr_n ? ST_RD : ST_WR;  // T_LOAD_RD / T_LOAD_WR
            else
                state_d = ST_IDLE;               // T_DESEL
        end else begin
            unique case (state_q)
                ST_RD, ST_WR: begin              // T_CONT
                    cnt_d    = cnt_q + 2'd1;
                    acc_addr = {base_q[ADDR_W-1:2],
                                burst_lo(base_q[1:0], cnt_q + 2'd1, ilv)};
                end
                default: state_d = ST_IDLE;      // T_NOP
            endcase
        end
        acc_valid = en && (state_d != ST_IDLE);
        acc_wr    = (state_d == ST_WR);
    end

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/zbt_array.sv
`timescale 1ns/1ps
module zbt_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  acc_valid,
    input  logic                  acc_wr,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic [DATA_W/8-1:0]   be_n,
    input  logic [DATA_W-1:0]     din,
    output logic [DATA_W-1:0]     rd_word
);

    localparam int NB    = DATA_W / 8;
    localparam int DEPTH = 1 << ADDR_W;

    logic              wr_pend_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [NB-1:0]     wr_be_n_q;
    logic              hit;

    // Delayed-write register: command now, data on the next enabled edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_pend_q <= 1'b0;
            wr_addr_q <= '0;
            wr_be_n_q <= '1;
        end else if (en) begin
            wr_pend_q <= acc_valid && acc_wr;
            wr_addr_q <= acc_addr;
            wr_be_n_q <= be_n;
        end
    end

    assign hit = wr_pend_q && (wr_addr_q == acc_addr);

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (en && wr_pend_q && !wr_be_n_q[g])
                lane_mem[wr_addr_q] <= din[g*8 +: 8];
        end

        // Forward the completing write's lane to a read of the same word.
        assign rd_word[g*8 +: 8] = (hit && !wr_be_n_q[g]) ? din[g*8 +: 8]
                                                          : lane_mem[acc_addr];
    end

endmodule

// File: rtl/zbt_outstage.sv
`timescale 1ns/1ps
module zbt_outstage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sleep,
    input  logic              acc_valid,
    input  logic              acc_wr,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    logic              rd_valid_q;
    logic [DATA_W-1:0] dq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            dq_q       <= '0;
        end else if (sleep) begin
            rd_valid_q <= 1'b0;
        end else if (en) begin
            rd_valid_q <= acc_valid && !acc_wr;
            if (acc_valid && !acc_wr)
                dq_q <= rd_word;
        end
    end

    assign dq_oe  = rd_valid_q && !oe_n;
    assign dq_out = dq_oe ? dq_q : '0;

endmodule

// File: rtl/zbt_sram.sv
`timescale 1ns/1ps
module zbt_sram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                sel1_n,
    input  logic                sel2,
    input  logic                sel3_n,
    input  logic                wr_n,
    input  logic                clk_en_n,
    input  logic                adv_ld,
    input  logic [DATA_W/8-1:0] byte_en_n,
    input  logic                burst_ilv,
    input  logic                sleep,
    input  logic                oe_n,
    input  logic [DATA_W-1:0]   dq_in,
    output logic [DATA_W-1:0]   dq_out,
    output logic                dq_oe
);

    logic              en;
    logic              selected;
    logic              acc_valid;
    logic              acc_wr;
    logic [ADDR_W-1:0] acc_addr;
    logic              busy;
    logic [DATA_W-1:0] rd_word;

    assign en       = !clk_en_n && !sleep;
    assign selected = !sel1_n && sel2 && !sel3_n;

    zbt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .sleep(sleep),
        .selected(selected), .wr_n(wr_n), .adv_ld(adv_ld),
        .ilv(burst_ilv), .addr(addr),
        .acc_valid(acc_valid), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .busy(busy)
    );

    zbt_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n), .en(en),
        .acc_valid(acc_valid), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .be_n(byte_en_n), .din(dq_in), .rd_word(rd_word)
    );

    zbt_outstage #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .en(en), .sleep(sleep),
        .acc_valid(acc_valid), .acc_wr(acc_wr), .rd_word(rd_word),
        .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe)
    );

endmodule

// File: rtl/zbt_chk.sv
`timescale 1ns/1ps
module zbt_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en_n,
    input logic              sleep,
    input logic              adv_ld,
    input logic              sel1_n,
    input logic              sel2,
    input logic              sel3_n,
    input logic              wr_n,
    input logic              oe_n,
    input logic              busy,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe
);

    logic live;
    logic chosen;
    assign live   = !clk_en_n && !sleep;
    assign chosen = !sel1_n && sel2 && !sel3_n;

    p_desel_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !adv_ld && !chosen) |=> !dq_oe);

    p_write_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !adv_ld && chosen && !wr_n) |=> busy);

    p_read_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !adv_ld && chosen && wr_n) |=> (oe_n || dq_oe));

    p_oe_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !oe_n);

    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_n && !sleep && !oe_n) |=> (oe_n || $stable(dq_out)));

    p_nop_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (live && adv_ld && !busy) |=> !dq_oe);

    p_sleep_hiz_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (!dq_oe && !busy));

endmodule

bind zbt_sram zbt_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sleep(sleep),
    .adv_ld(adv_ld), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .wr_n(wr_n), .oe_n(oe_n), .busy(busy), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/sim_zbt_sram.sv
`timescale 1ns/1ps
module sim_zbt_sram;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        sel1_n = 1'b1, sel2 = 1'b1, sel3_n = 1'b0;
    logic        wr_n = 1'b1, clk_en_n = 1'b0, adv_ld = 1'b0;
    logic [1:0]  byte_en_n = 2'b11;
    logic        burst_ilv = 1'b0, sleep = 1'b0, oe_n = 1'b0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic        dq_oe;

    zbt_sram #(.ADDR_W(8), .DATA_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel1_n(sel1_n), .sel2(sel2),
        .sel3_n(sel3_n), .wr_n(wr_n), .clk_en_n(clk_en_n), .adv_ld(adv_ld),
        .byte_en_n(byte_en_n), .burst_ilv(burst_ilv), .sleep(sleep),
        .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #4 clk = ~clk;   // 125 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        int          due;
        bit          drv;
        logic [15:0] dat;
        string       tag;
    } exp_t;

    exp_t sb[$];
    exp_t last_it;
    exp_t mon_it;

    // Reference model state, from the requirements.
    logic [15:0] mm [256];
    bit          pend = 0;
    logic [7:0]  pa = '0;
    logic [1:0]  pbe = 2'b11;
    int          b_op = 0;      // 0 idle, 1 read, 2 write
    logic [7:0]  b_base = '0;
    logic [1:0]  b_cnt = '0;
    logic        g_ilv = 1'b0;
    logic        g_oen = 1'b0;

    task automatic check(input bit ok, input string tag,
                         input logic [16:0] act, input logic [16:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got {oe,dq}=%h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one command per cycle, pushes its expected result.
    task automatic step(input bit c_n, input bit ad, input bit [2:0] ce,
                        input bit w_n, input logic [7:0] a, input logic [1:0] be,
                        input logic [15:0] d, input bit zz, input string tag);
        exp_t it;
        logic [7:0] acc;
        @(posedge clk); #1;
        clk_en_n = c_n; adv_ld = ad; sel1_n = ce[2]; sel2 = ce[1];
        sel3_n = ce[0]; wr_n = w_n; addr = a; byte_en_n = be; dq_in = d;
        sleep = zz; burst_ilv = g_ilv; oe_n = g_oen;
        it.due = cyc + 1; it.tag = tag; it.drv = 0; it.dat = '0;
        acc = a;
        if (zz) begin
            b_op = 0;
        end else if (c_n) begin
            it.drv = last_it.drv; it.dat = last_it.dat;
        end else begin
            if (pend) begin
                if (!pbe[0]) mm[pa][7:0]  = d[7:0];
                if (!pbe[1]) mm[pa][15:8] = d[15:8];
            end
            pend = 0;
            if (!ad) begin
                if (ce == 3'b010) begin
                    b_op = w_n ? 1 : 2; b_base = a; b_cnt = 0; acc = a;
                end else b_op = 0;
            end else if (b_op != 0) begin
                b_cnt = b_cnt + 2'd1;
                acc = {b_base[7:2], g_ilv ? (b_base[1:0] ^ b_cnt)
                                          : (b_base[1:0] + b_cnt)};
            end
            if (b_op == 1) begin it.drv = 1; it.dat = mm[acc]; end
            if (b_op == 2) begin pend = 1; pa = acc; pbe = be; end
        end
        last_it = it;
        sb.push_back(it);
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] d, input string t);
        step(0, 0, 3'b010, 1, a, 2'b11, d, 0, t);
    endtask
    task automatic wr(input logic [7:0] a, input logic [1:0] be,
                      input logic [15:0] d, input string t);
        step(0, 0, 3'b010, 0, a, be, d, 0, t);
    endtask
    task automatic cont(input logic [15:0] d, input string t);
        step(0, 1, 3'b010, 1, 8'h00, 2'b00, d, 0, t);
    endtask
    task automatic stall(input logic [15:0] d, input string t);
        step(1, 0, 3'b010, 0, 8'hFF, 2'b00, d, 0, t);
    endtask
    task automatic desel(input bit [2:0] ce, input logic [15:0] d, input string t);
        step(0, 0, ce, 1, 8'h20, 2'b11, d, 0, t);
    endtask
    task automatic nap(input string t);
        step(0, 0, 3'b010, 0, 8'h20, 2'b00, 16'hFFFF, 1, t);
    endtask

    // Monitor: compare due items at the falling edge.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            logic [16:0] e;
            mon_it = sb.pop_front();
            e = (mon_it.drv && !oe_n) ? {1'b1, mon_it.dat} : 17'h0;
            check({dq_oe, dq_out} === e, mon_it.tag, {dq_oe, dq_out}, e);
        end
    end

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        last_it.due = 0; last_it.drv = 0; last_it.dat = '0; last_it.tag = "";
        repeat (3) @(posedge clk);
        #2;
        check({dq_oe, dq_out} === 17'h0, "R12 reset", {dq_oe, dq_out}, 17'h0);
        rst_n = 1'b1;
        desel(3'b110, 16'h0, "R12 first cycle");

        // R2: write data one enabled edge after its command
        wr(8'h10, 2'b00, 16'h0000, "R2 wr");
        wr(8'h11, 2'b00, 16'hA110, "R2 wr");
        rd(8'h10, 16'hB111, "R2 rd 10");
        rd(8'h11, 16'h0000, "R2 rd 11");
        // R10: read on the completing edge of the same address
        wr(8'h20, 2'b00, 16'h0000, "R10 wr");
        rd(8'h20, 16'hC220, "R10 fwd");
        // R3: only lane 0 enabled
        wr(8'h10, 2'b10, 16'h0000, "R3 wr");
        rd(8'h10, 16'h55EE, "R3 fwd lane");
        rd(8'h10, 16'h0000, "R3 stored lane");
        // R5/R6: stall on the data edge
        wr(8'h30, 2'b00, 16'h0000, "R6 wr");
        stall(16'hDEAD, "R5 stall");
        rd(8'h20, 16'h1234, "R6 complete");
        rd(8'h30, 16'h0000, "R6 rd 30");
        rd(8'h11, 16'h0000, "R5 rd");
        stall(16'h0000, "R5 hold");
        stall(16'h0000, "R5 hold2");
        // R4: output enable gating
        rd(8'h10, 16'h0000, "R4 rd");
        g_oen = 1'b1;
        stall(16'h0000, "R4 oe off");
        g_oen = 1'b0;
        stall(16'h0000, "R4 oe on");
        // R7: linear write burst from 0x42, then linear read from 0x41
        g_ilv = 1'b0;
        wr(8'h42, 2'b00, 16'h0000, "R7 wr");
        cont(16'hD000, "R7 wr c1");
        cont(16'hD001, "R7 wr c2");
        cont(16'hD002, "R7 wr c3");
        rd(8'h41, 16'hD003, "R7 rd 41");
        cont(16'h0000, "R7 rd 42");
        cont(16'h0000, "R7 rd 43");
        cont(16'h0000, "R7 rd 40 wrap");
        // R8: interleaved orders
        g_ilv = 1'b1;
        rd(8'h42, 16'h0000, "R8 rd 42");
        cont(16'h0000, "R8 rd 43");
        cont(16'h0000, "R8 rd 40");
        cont(16'h0000, "R8 rd 41");
        rd(8'h41, 16'h0000, "R8 rd 41");
        cont(16'h0000, "R8 rd 40");
        cont(16'h0000, "R8 rd 43");
        cont(16'h0000, "R8 rd 42");
        g_ilv = 1'b0;
        // R1: each select pin alone deselects
        rd(8'h20, 16'h0000, "R1 rd");
        desel(3'b110, 16'h0000, "R1 sel1 off");
        rd(8'h20, 16'h0000, "R1 rd");
        desel(3'b000, 16'h0000, "R1 sel2 off");
        rd(8'h20, 16'h0000, "R1 rd");
        desel(3'b011, 16'h0000, "R1 sel3 off");
        step(0, 0, 3'b110, 1, 8'h20, 2'b11, 16'h0, 0, "R1 read unselected");
        // R9: continue with nothing active
        cont(16'h0000, "R9 nop");
        cont(16'h0000, "R9 nop2");
        // R11: sleep ignores a write-looking command
        desel(3'b110, 16'h0000, "R11 pre");
        nap("R11 sleep");
        nap("R11 sleep");
        nap("R11 sleep");
        desel(3'b110, 16'hFFFF, "R11 wake");
        cont(16'h0000, "R11 after wake");
        rd(8'h20, 16'h0000, "R11 data kept");
        desel(3'b110, 16'h0000, "R1 end");
        repeat (3) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule